// File: doc/BRIEF.md
# Multipath Symbol Correction and Combining Engine

This block sits after the despreaders of a time-shared multipath receiver. Each despread complex symbol arrives tagged with the finger that produced it. The block multiplies the symbol by that finger's complex channel coefficient, which host software writes into a 16-entry table. It then adds the corrected value into the running sum of the user channel to which the finger is assigned. When every finger of that channel has contributed, the block emits the combined symbol, saturated to 16 bits, together with the channel index. Channels complete and emerge in whatever order their last finger arrives.

Only one axis of each user channel carries data, so the block computes only the wanted component of the product. One pair of real multipliers serves all sixteen fingers. The host sets each channel's finger count and data axis through a per-channel configuration write. Input flow control uses a ready signal. A finger symbol therefore waits at the input while the shared datapath is busy, and no symbol is lost.

A four-state controller sequences each symbol. WAIT_SYM accepts the symbol (transition *accept* to PRODUCT when `sym_valid` is high). PRODUCT forms the corrected component (transition *product_done* to MERGE). MERGE updates the channel sum and takes one of two exits: *partial* returns to WAIT_SYM when the channel is still missing fingers, and *complete* goes to PRESENT when the configured count has been reached. PRESENT shows the combined symbol for one cycle (transition *presented* back to WAIT_SYM).

Top module: `finger_combiner`

## Requirements
- R1: After reset `out_valid` is 0 and `sym_ready` is 1. Every coefficient is 0, every finger maps to channel 0, and every channel has count 0, real axis, and an empty sum.
- R2: Writing `coef_we` stores `coef_re`/`coef_im` for finger `coef_fid`. Any symbol from that finger accepted on a later edge uses the new value.
- R3: For a channel on the real axis (`chcfg_imag`=0) the corrected value is floor((re·cre − im·cim) / 2^15), where re and im are the symbol components and cre and cim are the coefficient components. All values are two's-complement 16-bit.
- R4: For a channel on the imaginary axis (`chcfg_imag`=1) the corrected value is floor((re·cim + im·cre) / 2^15).
- R5: Writing `map_we` assigns finger `map_fid` to channel `map_chan` (4-bit index). A finger's corrected values go only into its assigned channel's sum.
- R6: A channel emits once its number of contributions reaches its configured count, where a count of 0 acts as 1 and values above 16 act as 16. The emitted `out_chan` is the channel index. The channel's sum and contribution count then restart from zero.
- R7: The emitted `out_data` is the channel sum clamped to the range −32768..32767.
- R8: A symbol is accepted on an edge where `sym_valid` and `sym_ready` are both 1. `sym_ready` is then 0 for the next two cycles. If the symbol completes its channel, `out_valid` is 1 for exactly one cycle starting two cycles after acceptance and `sym_ready` returns one cycle later. Otherwise `sym_ready` returns two cycles after acceptance.
- R9: A channel configuration write (`chcfg_we`) sets the count and axis of channel `chcfg_chan` and discards that channel's partial sum and contribution count.
- R10: Channels accumulate independently. Symbols of different channels may interleave, and each channel emits when its own count is reached, regardless of arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient table write strobe |
| coef_fid | input | 4 | Finger whose coefficient is written |
| coef_re | input | 16 | Coefficient real part, signed |
| coef_im | input | 16 | Coefficient imaginary part, signed |
| map_we | input | 1 | Finger-to-channel map write strobe |
| map_fid | input | 4 | Finger being assigned |
| map_chan | input | 4 | Channel the finger is assigned to |
| chcfg_we | input | 1 | Channel configuration write strobe |
| chcfg_chan | input | 4 | Channel being configured |
| chcfg_count | input | 5 | Number of fingers combined for the channel |
| chcfg_imag | input | 1 | 1: data on imaginary axis, 0: real axis |
| sym_valid | input | 1 | Despread symbol present |
| sym_ready | output | 1 | Engine can take a symbol this cycle |
| sym_fid | input | 4 | Finger that produced the symbol |
| sym_re | input | 16 | Despread symbol real part, signed |
| sym_im | input | 16 | Despread symbol imaginary part, signed |
| out_valid | output | 1 | Combined symbol present (one cycle) |
| out_chan | output | 4 | Channel of the combined symbol |
| out_data | output | 16 | Saturated combined symbol, signed |

## Verification
The assertions assume that the host writes configuration only while the engine waits for a symbol and no symbol is being offered. Under that assumption, a cleared channel never races with a merge of the same channel. They also assume that configured counts stay within the finger population, so a channel's contribution counter cannot exceed fifteen. The stimulus follows these rules: every table or channel write is issued on cycles where `sym_valid` is low and `sym_ready` is high. Each symbol is held until it is accepted and then withdrawn on the following cycle.

// File: rtl/comb_pkg.sv
package comb_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_SYM = 2'd0,
        ST_PRODUCT  = 2'd1,
        ST_MERGE    = 2'd2,
        ST_PRESENT  = 2'd3
    } comb_state_e;
endpackage

// File: rtl/finger_table.sv
module finger_table #(
    parameter int NF  = 16,
    parameter int CW  = 16,
    parameter int NCH = 16,
    localparam int FIDW = $clog2(NF),
    localparam int CHW  = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 coef_we,
    input  logic [FIDW-1:0]      coef_fid,
    input  logic signed [CW-1:0] coef_re,
    input  logic signed [CW-1:0] coef_im,
    input  logic                 map_we,
    input  logic [FIDW-1:0]      map_fid,
    input  logic [CHW-1:0]       map_chan,
    input  logic [FIDW-1:0]      rd_fid,
    output logic signed [CW-1:0] rd_cre,
    output logic signed [CW-1:0] rd_cim,
    output logic [CHW-1:0]       rd_chan
);
    logic signed [CW-1:0] cre_q [NF];
    logic signed [CW-1:0] cim_q [NF];
    logic [CHW-1:0]       chan_q [NF];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) begin
                cre_q[i]  <= '0;
                cim_q[i]  <= '0;
                chan_q[i] <= '0;
            end
        end else begin
            if (coef_we) begin
                cre_q[coef_fid] <= coef_re;
                cim_q[coef_fid] <= coef_im;
            end
            if (map_we) begin
                chan_q[map_fid] <= map_chan;
            end
        end
    end

    assign rd_cre  = cre_q[rd_fid];
    assign rd_cim  = cim_q[rd_fid];
    assign rd_chan = chan_q[rd_fid];

    // a coefficient write shows up on the read port one cycle later
    AST_COEF_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_we && !map_we && !$isunknown(coef_fid)) |=> (cre_q[$past(coef_fid)] == $past(coef_re))); // R2
endmodule

// File: rtl/reduced_cmul.sv
module reduced_cmul #(
    parameter int DW   = 16,
    parameter int FRAC = 15,
    localparam int SUMW  = 2*DW + 1,
    localparam int CORRW = SUMW - FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    use_imag,
    input  logic signed [DW-1:0]    op_re,
    input  logic signed [DW-1:0]    op_im,
    input  logic signed [DW-1:0]    op_cre,
    input  logic signed [DW-1:0]    op_cim,
    output logic signed [CORRW-1:0] corr
);
    logic signed [DW-1:0]   mul_a_rhs;
    logic signed [DW-1:0]   mul_b_rhs;
    logic signed [2*DW-1:0] prod_a;
    logic signed [2*DW-1:0] prod_b;
    logic signed [SUMW-1:0] ext_a;
    logic signed [SUMW-1:0] ext_b;
    logic signed [SUMW-1:0] wanted;

    // steer the coefficient halves so that two multipliers give either axis
    always_comb begin
        mul_a_rhs = use_imag ? op_cim : op_cre;
        mul_b_rhs = use_imag ? op_cre : op_cim;
        prod_a    = op_re * mul_a_rhs;
        prod_b    = op_im * mul_b_rhs;
        ext_a     = {prod_a[2*DW-1], prod_a};
        ext_b     = {prod_b[2*DW-1], prod_b};
        wanted    = use_imag ? (ext_a + ext_b) : (ext_a - ext_b);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr <= '0;
        end else if (en) begin
            corr <= wanted[SUMW-1:FRAC];
        end
    end
endmodule

// File: rtl/chan_accum.sv
module chan_accum #(
    parameter int NCH   = 16,
    parameter int NF    = 16,
    parameter int CORRW = 18,
    parameter int OW    = 16,
    localparam int CHW  = $clog2(NCH),
    localparam int CNTW = $clog2(NF + 1),
    localparam int ACCW = CORRW + CNTW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CHW-1:0]          cfg_chan,
    input  logic [CNTW-1:0]         cfg_count,
    input  logic                    cfg_imag,
    input  logic [CHW-1:0]          rd_chan,
    output logic                    rd_imag,
    input  logic                    upd_en,
    input  logic signed [CORRW-1:0] corr,
    output logic                    upd_done,
    output logic signed [OW-1:0]    sum_out
);
    logic signed [ACCW-1:0] acc_q  [NCH];
    logic [CNTW-1:0]        seen_q [NCH];
    logic [CNTW-1:0]        need_q [NCH];
    logic                   imag_q [NCH];

    logic [CNTW-1:0]        need_eff;
    logic signed [ACCW-1:0] sum_next;
    logic signed [OW-1:0]   sum_clamped;
    logic                   in_range;

    always_comb begin
        if (need_q[rd_chan] == '0) begin
            need_eff = CNTW'(1);
        end else if (need_q[rd_chan] > CNTW'(NF)) begin
            need_eff = CNTW'(NF);
        end else begin
            need_eff = need_q[rd_chan];
        end
        sum_next = acc_q[rd_chan] + {{(ACCW-CORRW){corr[CORRW-1]}}, corr};
        upd_done = upd_en && ((seen_q[rd_chan] + CNTW'(1)) >= need_eff);
        in_range = (&sum_next[ACCW-1:OW-1]) || !(|sum_next[ACCW-1:OW-1]);
        if (in_range) begin
            sum_clamped = sum_next[OW-1:0];
        end else if (sum_next[ACCW-1]) begin
            sum_clamped = {1'b1, {(OW-1){1'b0}}};
        end else begin
            sum_clamped = {1'b0, {(OW-1){1'b1}}};
        end
    end

    assign rd_imag = imag_q[rd_chan];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                acc_q[c]  <= '0;
                seen_q[c] <= '0;
                need_q[c] <= '0;
                imag_q[c] <= 1'b0;
            end
            sum_out <= '0;
        end else begin
            if (upd_en) begin
                if (upd_done) begin
                    acc_q[rd_chan]  <= '0;
                    seen_q[rd_chan] <= '0;
                    sum_out         <= sum_clamped;
                end else begin
                    acc_q[rd_chan]  <= sum_next;
                    seen_q[rd_chan] <= seen_q[rd_chan] + CNTW'(1);
                end
            end
            // configuration wins over a merge into the same channel
            if (cfg_we) begin
                need_q[cfg_chan] <= cfg_count;
                imag_q[cfg_chan] <= cfg_imag;
                acc_q[cfg_chan]  <= '0;
                seen_q[cfg_chan] <= '0;
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            seen_q[g] < CNTW'(NF)); // R6
        AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_chan == CHW'(g)) |=> (seen_q[g] == '0 && acc_q[g] == '0)); // R9
    end
endmodule

// File: rtl/finger_combiner.sv
module finger_combiner #(
    parameter int NF    = 16,
    parameter int NCH   = 16,
    parameter int DW    = 16,
    parameter int FRAC  = 15,
    parameter int OW    = 16,
    localparam int FIDW  = $clog2(NF),
    localparam int CHW   = $clog2(NCH),
    localparam int CNTW  = $clog2(NF + 1),
    localparam int CORRW = 2*DW + 1 - FRAC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            coef_we,
    input  logic [FIDW-1:0] coef_fid,
    input  logic [DW-1:0]   coef_re,
    input  logic [DW-1:0]   coef_im,
    input  logic            map_we,
    input  logic [FIDW-1:0] map_fid,
    input  logic [CHW-1:0]  map_chan,
    input  logic            chcfg_we,
    input  logic [CHW-1:0]  chcfg_chan,
    input  logic [CNTW-1:0] chcfg_count,
    input  logic            chcfg_imag,
    input  logic            sym_valid,
    output logic            sym_ready,
    input  logic [FIDW-1:0] sym_fid,
    input  logic [DW-1:0]   sym_re,
    input  logic [DW-1:0]   sym_im,
    output logic            out_valid,
    output logic [CHW-1:0]  out_chan,
    output logic [OW-1:0]   out_data
);
    import comb_pkg::*;

    comb_state_e state_q, state_d;

    logic                    take_sym;
    logic                    mul_en;
    logic                    upd_en;
    logic                    upd_done;
    logic                    axis_imag;
    logic signed [DW-1:0]    tbl_cre, tbl_cim;
    logic [CHW-1:0]          tbl_chan;
    logic signed [DW-1:0]    op_re_q, op_im_q, op_cre_q, op_cim_q;
    logic [CHW-1:0]          ch_q;
    logic signed [CORRW-1:0] corr;
    logic signed [OW-1:0]    sum_out;

    finger_table #(.NF(NF), .CW(DW), .NCH(NCH)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .coef_we  (coef_we),
        .coef_fid (coef_fid),
        .coef_re  ($signed(coef_re)),
        .coef_im  ($signed(coef_im)),
        .map_we   (map_we),
        .map_fid  (map_fid),
        .map_chan (map_chan),
        .rd_fid   (sym_fid),
        .rd_cre   (tbl_cre),
        .rd_cim   (tbl_cim),
        .rd_chan  (tbl_chan)
    );

    reduced_cmul #(.DW(DW), .FRAC(FRAC)) u_cmul (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mul_en),
        .use_imag (axis_imag),
        .op_re    (op_re_q),
        .op_im    (op_im_q),
        .op_cre   (op_cre_q),
        .op_cim   (op_cim_q),
        .corr     (corr)
    );

    chan_accum #(.NCH(NCH), .NF(NF), .CORRW(CORRW), .OW(OW)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (chcfg_we),
        .cfg_chan  (chcfg_chan),
        .cfg_count (chcfg_count),
        .cfg_imag  (chcfg_imag),
        .rd_chan   (ch_q),
        .rd_imag   (axis_imag),
        .upd_en    (upd_en),
        .corr      (corr),
        .upd_done  (upd_done),
        .sum_out   (sum_out)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_SYM;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_SYM: if (sym_valid) state_d = ST_PRODUCT;
            ST_PRODUCT:  state_d = ST_MERGE;
            ST_MERGE:    state_d = upd_done ? ST_PRESENT : ST_WAIT_SYM;
            ST_PRESENT:  state_d = ST_WAIT_SYM;
            default:     state_d = ST_WAIT_SYM;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        sym_ready = 1'b0;
        mul_en    = 1'b0;
        upd_en    = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_WAIT_SYM: sym_ready = 1'b1;
            ST_PRODUCT:  mul_en    = 1'b1;
            ST_MERGE:    upd_en    = 1'b1;
            ST_PRESENT:  out_valid = 1'b1;
            default:     ;
        endcase
    end

    assign take_sym = sym_valid && sym_ready;

    // operand capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_re_q  <= '0;
            op_im_q  <= '0;
            op_cre_q <= '0;
            op_cim_q <= '0;
            ch_q     <= '0;
        end else if (take_sym) begin
            op_re_q  <= $signed(sym_re);
            op_im_q  <= $signed(sym_im);
            op_cre_q <= tbl_cre;
            op_cim_q <= tbl_cim;
            ch_q     <= tbl_chan;
        end
    end

    assign out_chan = ch_q;
    assign out_data = sum_out;

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        take_sym |=> !sym_ready); // R8
    AST_PRESENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R8
    AST_PRESENT_AFTER_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(upd_done)); // R6
    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $stable(out_chan)); // R6
endmodule

// File: tb/finger_combiner_tb_top.sv
module finger_combiner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coef_we = 0, map_we = 0, chcfg_we = 0, sym_valid = 0, chcfg_imag = 0;
    logic [3:0]  coef_fid = 0, map_fid = 0, map_chan = 0, chcfg_chan = 0, sym_fid = 0;
    logic [15:0] coef_re = 0, coef_im = 0, sym_re = 0, sym_im = 0;
    logic [4:0]  chcfg_count = 0;
    logic        sym_ready, out_valid;
    logic [3:0]  out_chan;
    logic [15:0] out_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // behavioural model state
    int m_cre [16];
    int m_cim [16];
    int m_map [16];
    int m_cnt [16];
    int m_img [16];
    longint m_acc [16];
    int m_seen [16];
    int q_chan [$];
    int q_data [$];
    int q_due [$];
    string q_tag [$];

    finger_combiner dut_i (
        .clk(clk), .rst_n(rst_n),
        .coef_we(coef_we), .coef_fid(coef_fid), .coef_re(coef_re), .coef_im(coef_im),
        .map_we(map_we), .map_fid(map_fid), .map_chan(map_chan),
        .chcfg_we(chcfg_we), .chcfg_chan(chcfg_chan), .chcfg_count(chcfg_count),
        .chcfg_imag(chcfg_imag),
        .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_fid(sym_fid),
        .sym_re(sym_re), .sym_im(sym_im),
        .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_v;
            exp_v = (q_due.size() > 0) && (q_due[0] == cyc);
            if (exp_v || out_valid) begin
                if (!exp_v) begin
                    check(1'b0, "R6 unexpected emission", int'(out_valid), 0);
                end else if (!out_valid) begin
                    check(1'b0, {q_tag[0], " missing emission"}, 0, 1);
                end else begin
                    check(int'(out_chan) == q_chan[0], {q_tag[0], " chan"}, int'(out_chan), q_chan[0]);
                    check(int'($signed(out_data)) == q_data[0], {q_tag[0], " data"},
                          int'($signed(out_data)), q_data[0]);
                end
                if (exp_v) begin
                    void'(q_chan.pop_front()); void'(q_data.pop_front());
                    void'(q_due.pop_front());  void'(q_tag.pop_front());
                end
            end
        end
    end

    task automatic wr_coef(int f, int re, int im);
        @(negedge clk);
        coef_we = 1; coef_fid = 4'(f); coef_re = 16'(re); coef_im = 16'(im);
        m_cre[f] = re; m_cim[f] = im;
        @(negedge clk);
        coef_we = 0;
    endtask

    task automatic wr_map(int f, int ch);
        @(negedge clk);
        map_we = 1; map_fid = 4'(f); map_chan = 4'(ch);
        m_map[f] = ch;
        @(negedge clk);
        map_we = 0;
    endtask

    task automatic wr_chan(int ch, int cnt, int img);
        @(negedge clk);
        chcfg_we = 1; chcfg_chan = 4'(ch); chcfg_count = 5'(cnt); chcfg_imag = img[0];
        m_cnt[ch] = cnt; m_img[ch] = img; m_acc[ch] = 0; m_seen[ch] = 0;
        @(negedge clk);
        chcfg_we = 0;
    endtask

    task automatic send(int f, int re, int im, string tag);
        int ch;
        int need;
        longint p;
        bit fin;
        @(negedge clk);
        while (!sym_ready) @(negedge clk);
        ch = m_map[f];
        if (m_img[ch] != 0) p = longint'(re) * m_cim[f] + longint'(im) * m_cre[f];
        else                p = longint'(re) * m_cre[f] - longint'(im) * m_cim[f];
        p = p >>> 15;
        m_acc[ch] += p;
        m_seen[ch]++;
        need = (m_cnt[ch] == 0) ? 1 : ((m_cnt[ch] > 16) ? 16 : m_cnt[ch]);
        fin = (m_seen[ch] >= need);
        if (fin) begin
            longint s;
            s = m_acc[ch];
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
            q_chan.push_back(ch); q_data.push_back(int'(s));
            q_due.push_back(cyc + 3); q_tag.push_back(tag);
            m_acc[ch] = 0; m_seen[ch] = 0;
        end
        sym_valid = 1; sym_fid = 4'(f); sym_re = 16'(re); sym_im = 16'(im);
        @(negedge clk);
        sym_valid = 0;
        check(sym_ready == 1'b0, "R8 ready low +1", int'(sym_ready), 0);
        @(negedge clk);
        check(sym_ready == 1'b0, "R8 ready low +2", int'(sym_ready), 0);
        @(negedge clk);
        check(sym_ready == !fin, "R8 ready return", int'(sym_ready), int'(!fin));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_cre[i] = 0; m_cim[i] = 0; m_map[i] = 0; m_cnt[i] = 0;
            m_img[i] = 0; m_acc[i] = 0; m_seen[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        rst_n = 1;
        @(negedge clk);
        check(sym_ready == 1'b1, "R1 sym_ready", int'(sym_ready), 1);
        // R1: zero coefficients, channel 0, count 0 acting as 1
        send(5, 1000, -2000, "R1");

        // R3 R5 R6: four fingers onto channel 2, real axis
        for (int f = 0; f < 4; f++) wr_map(f, 2);
        wr_coef(0, 16384, 0);
        wr_coef(1, 0, 16384);
        wr_coef(2, -8192, 4096);
        wr_coef(3, 32767, -32768);
        wr_chan(2, 4, 0);
        send(0, 1200, -300, "R3");
        send(1, 500, 700, "R3");
        send(2, -900, 1500, "R5");
        send(3, 40, -60, "R6");

        // R3: floor of a small negative product
        wr_map(6, 9); wr_coef(6, 1, 0); wr_chan(9, 1, 0);
        send(6, -1, 0, "R3 floor");

        // R4: imaginary axis, two fingers on channel 5
        wr_map(7, 5); wr_map(8, 5);
        wr_coef(7, 12000, -7000); wr_coef(8, -3000, 20000);
        wr_chan(5, 2, 1);
        send(7, 800, 1600, "R4");
        send(8, -2500, 300, "R4");

        // R10: interleaved channels, later-started channel completes first
        wr_map(9, 7); wr_map(10, 7); wr_map(11, 7);
        wr_map(12, 1); wr_map(13, 1);
        for (int f = 9; f < 14; f++) wr_coef(f, 16384 + f * 100, -f * 50);
        wr_chan(7, 3, 0); wr_chan(1, 2, 0);
        send(9, 300, 200, "R10");
        send(12, -400, 100, "R10");
        send(10, 1000, -100, "R10");
        send(13, 250, 250, "R10");
        send(11, -50, 75, "R10");

        // R7: positive and negative saturation on channel 11
        for (int f = 0; f < 4; f++) begin wr_map(f, 11); wr_coef(f, 32767, 0); end
        wr_chan(11, 4, 0);
        for (int k = 0; k < 4; k++) send(k, 32767, 0, "R7 pos");
        for (int k = 0; k < 4; k++) send(k, -32768, 0, "R7 neg");

        // R9: reconfiguration discards partial sum
        wr_chan(11, 3, 0);
        send(0, 10000, 0, "R9");
        send(1, 10000, 0, "R9");
        wr_chan(11, 2, 0);
        send(2, 300, 0, "R9");
        send(3, -700, 0, "R9");

        // R2: new coefficient used by following symbol
        wr_chan(11, 1, 0);
        send(0, 2000, 0, "R2 old");
        wr_coef(0, -16384, 0);
        send(0, 2000, 0, "R2 new");

        // R6: count above 16 acts as 16 on channel 4
        for (int f = 0; f < 16; f++) wr_map(f, 4);
        wr_chan(4, 25, 0);
        for (int f = 0; f < 16; f++) send(f, 100 * f - 700, 30 * f, "R6 clamp count");

        // mixed traffic on four channels
        for (int f = 0; f < 16; f++) begin
            wr_map(f, f % 4);
            wr_coef(f, int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768);
        end
        for (int c = 0; c < 4; c++) wr_chan(c, c + 1, c % 2);
        for (int k = 0; k < 60; k++)
            send(int'($urandom_range(15)), int'($urandom_range(65535)) - 32768,
                 int'($urandom_range(65535)) - 32768, "R10 mixed");

        repeat (6) @(negedge clk);
        check(q_due.size() == 0, "R6 pending emissions", q_due.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule